// File: doc/BRIEF.md
# Segmented Approximate Adder with Guard Blocks

This block adds two unsigned operands of `WIDTH` bits. It gives up exactness on rare input patterns so that its carry path stays short. The operands are cut into slices of `BLK` bits. Each slice forms its sum bits with a small ripple-carry chain.

The carry entering an ordinary slice does not come from the full chain below it. A lookahead generator predicts it from the operand bits of the next lower slice alone, assuming that slice receives no carry. A carry that would have to cross more than one slice is therefore dropped. The lowest slice always starts from a carry of zero.

The top `GUARD` slices behave differently. They pass their carries to one another through the full ripple path, so errors in the most significant bits are reduced in both frequency and size. The lowest guard slice still takes a predicted carry. When `GUARD` equals the number of slices, the adder is exact.

The block is purely combinational. An optional carry-out is selected by `CARRY_OUT`.

Top module: `seg_approx_adder`

## Requirements
- R1: Every slice outputs the low `BLK` bits of the sum of its own two operand slices plus the carry that enters it, and its carry-out is bit `BLK` of that sum.
- R2: For slice i, where 1 <= i <= NB-GUARD and NB = WIDTH/BLK, the incoming carry equals the carry that slice i-1 would produce with a zero carry-in.
- R3: Slice 0 receives a carry-in of 0, so `sum_out[BLK-1:0]` always equals the low `BLK` bits of `a_in + b_in`.
- R4: The top `GUARD` slices together form one exact addition. Their sum bits, together with the final carry, equal the sum of those operand bits plus the carry that R2 predicts into the lowest guard slice.
- R5: With `GUARD` equal to WIDTH/BLK, `{carry_out, sum_out}` equals `a_in + b_in` for every input.
- R6: A mismatch between `sum_out` and the exact sum occurs only when there is a long chain. A long chain means that, at some slice i with 1 <= i <= NB-GUARD, the exact carry into slice i-1 is 1 and every bit of slice i-1 propagates (a XOR b all ones).
- R7: With `CARRY_OUT`=1, `carry_out` is the carry out of the top slice under the rules above. With `CARRY_OUT`=0, `carry_out` is held at 0.
- R8: The parameters must satisfy these conditions, and elaboration stops otherwise: `WIDTH` is divisible by `BLK`, and 1 <= `GUARD` <= WIDTH/BLK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| sum_out | output | WIDTH | Approximate sum |
| carry_out | output | 1 | Carry out of the top slice, or 0 when disabled |

## Verification
The bench goes after carries that must cross a whole slice, such as all-ones plus one and operands built from alternating propagate runs. A design that chained ordinary slices fully would give the exact sum where the approximation is expected to drop a carry. A design that fed a zero into the lowest guard slice, or broke the guard chain, would differ in the top bits, and this shows up when one setting of `GUARD` is compared with another. A mis-wired slice 0 or a predictor that looks at the wrong slice would produce errors on inputs without a long chain. The rule that any error implies a long chain catches that case. The fully guarded and no-carry-out instances expose a wrong exact path or a leaking `carry_out`.

// File: rtl/seg_approx_pkg.sv
package seg_approx_pkg;
   // number of slices for a given width and slice size
   function automatic int slice_count(input int width, input int blk);
      return width / blk;
   endfunction
endpackage

// File: rtl/sa_lookahead.sv
module sa_lookahead #(
   parameter int BLK = 4
) (
   input  logic [BLK-1:0] a_sl,
   input  logic [BLK-1:0] b_sl,
   output logic           gen_out
);
   logic [BLK-1:0] g_bit;
   logic [BLK-1:0] p_bit;

   assign g_bit = a_sl & b_sl;
   assign p_bit = a_sl ^ b_sl;

   // two-level sum of products: some bit generates and all above it propagate
   always_comb begin
      logic term;
      gen_out = 1'b0;
      for (int j = 0; j < BLK; j++) begin
         term = g_bit[j];
         for (int m = j + 1; m < BLK; m++) begin
            term = term & p_bit[m];
         end
         gen_out = gen_out | term;
      end
   end
endmodule

// File: rtl/sa_ripple_slice.sv
module sa_ripple_slice #(
   parameter int BLK = 4
) (
   input  logic [BLK-1:0] a_sl,
   input  logic [BLK-1:0] b_sl,
   input  logic           c_in,
   output logic [BLK-1:0] s_sl,
   output logic           c_out
);
   logic [BLK:0] chain;

   assign chain[0] = c_in;

   for (genvar j = 0; j < BLK; j++) begin : g_bit
      assign s_sl[j]      = a_sl[j] ^ b_sl[j] ^ chain[j];
      assign chain[j + 1] = (a_sl[j] & b_sl[j]) | (chain[j] & (a_sl[j] ^ b_sl[j]));
   end

   assign c_out = chain[BLK];

   always_comb begin
      assert_slice_sum_R1 : assert ({c_out, s_sl} ==
         ({1'b0, a_sl} + {1'b0, b_sl} + {{BLK{1'b0}}, c_in}))
         else $error("slice sum mismatch");
   end
endmodule

// File: rtl/seg_approx_adder.sv
module seg_approx_adder #(
   parameter int WIDTH     = 16,
   parameter int BLK       = 4,
   parameter int GUARD     = 1,
   parameter bit CARRY_OUT = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out
);
   import seg_approx_pkg::*;

   localparam int NB    = slice_count(WIDTH, BLK);
   localparam int LOWG  = NB - GUARD;
   localparam int GBITS = GUARD * BLK;

   // R8: parameter legality
   if ((WIDTH % BLK) != 0) begin : g_bad_div
      $error("WIDTH must be a multiple of BLK (R8)");
   end
   if (GUARD < 1 || GUARD > NB) begin : g_bad_guard
      $error("GUARD must lie in 1..WIDTH/BLK (R8)");
   end

   logic [NB-1:0] sl_cin;
   logic [NB-1:0] sl_cout;
   logic [NB:0]   sl_gen;

   assign sl_gen[NB] = 1'b0;

   for (genvar i = 0; i < NB; i++) begin : g_slice
      // carry selection per slice kind
      if (i == 0) begin : g_first
         assign sl_cin[i] = 1'b0;
      end else if (i <= LOWG) begin : g_pred
         assign sl_cin[i] = sl_gen[i-1];
      end else begin : g_chain
         assign sl_cin[i] = sl_cout[i-1];
      end

      // predictors only where an upper slice consumes them
      if (i < LOWG) begin : g_la
         sa_lookahead #(.BLK(BLK)) u_la (
            .a_sl    (a_in[i*BLK +: BLK]),
            .b_sl    (b_in[i*BLK +: BLK]),
            .gen_out (sl_gen[i])
         );
      end else begin : g_no_la
         assign sl_gen[i] = 1'b0;
      end

      sa_ripple_slice #(.BLK(BLK)) u_rs (
         .a_sl  (a_in[i*BLK +: BLK]),
         .b_sl  (b_in[i*BLK +: BLK]),
         .c_in  (sl_cin[i]),
         .s_sl  (sum_out[i*BLK +: BLK]),
         .c_out (sl_cout[i])
      );

      if (i >= 1 && i <= LOWG) begin : g_chk_pred
         always_comb begin
            if (!(sl_cin[i-1] && (&(a_in[(i-1)*BLK +: BLK] ^ b_in[(i-1)*BLK +: BLK])))) begin
               assert_pred_carry_R2 : assert (sl_cin[i] == sl_cout[i-1])
                  else $error("predicted carry differs without a long chain");
            end
         end
      end
   end

   if (CARRY_OUT) begin : g_cout
      assign carry_out = sl_cout[NB-1];
   end else begin : g_nocout
      assign carry_out = 1'b0;
   end

   logic [BLK:0]   low_exact;
   logic [GBITS:0] guard_exact;
   logic [WIDTH:0] full_exact;

   assign low_exact   = {1'b0, a_in[BLK-1:0]} + {1'b0, b_in[BLK-1:0]};
   assign guard_exact = {1'b0, a_in[WIDTH-1 -: GBITS]} + {1'b0, b_in[WIDTH-1 -: GBITS]}
                        + {{GBITS{1'b0}}, sl_cin[LOWG]};
   assign full_exact  = {1'b0, a_in} + {1'b0, b_in};

   always_comb begin
      assert_first_slice_R3 : assert (sum_out[BLK-1:0] == low_exact[BLK-1:0])
         else $error("first slice not exact");
      assert_guard_chain_R4 : assert ({sl_cout[NB-1], sum_out[WIDTH-1 -: GBITS]} == guard_exact)
         else $error("guard region not chained");
      if (!CARRY_OUT) begin
         assert_cout_off_R7 : assert (carry_out == 1'b0)
            else $error("carry_out active while disabled");
      end
      if (GUARD == NB) begin
         assert_full_exact_R5 : assert ({sl_cout[NB-1], sum_out} == full_exact)
            else $error("fully guarded adder not exact");
      end
   end
endmodule

// File: tb/seg_approx_adder_bench.sv
module seg_approx_adder_bench;
   localparam int N  = 16;
   localparam int W  = 4;
   localparam int NB = N / W;

   typedef struct {
      logic [N-1:0] a;
      logic [N-1:0] b;
      logic [N:0]   e_k1;
      logic [N:0]   e_k2;
      logic [N:0]   e_full;
      logic         chain_k1;
      logic         chain_k2;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [N-1:0] a_in = '0;
   logic [N-1:0] b_in = '0;
   logic [N-1:0] s_k1, s_k2, s_full, s_nc;
   logic         c_k1, c_k2, c_full, c_nc;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 1'b0;
   item_t sb[$];

   seg_approx_adder #(.WIDTH(N), .BLK(W), .GUARD(1), .CARRY_OUT(1'b1)) u_seg_approx_adder (
      .a_in(a_in), .b_in(b_in), .sum_out(s_k1), .carry_out(c_k1));
   seg_approx_adder #(.WIDTH(N), .BLK(W), .GUARD(2), .CARRY_OUT(1'b1)) u_seg_approx_adder_k2 (
      .a_in(a_in), .b_in(b_in), .sum_out(s_k2), .carry_out(c_k2));
   seg_approx_adder #(.WIDTH(N), .BLK(W), .GUARD(NB), .CARRY_OUT(1'b1)) u_seg_approx_adder_full (
      .a_in(a_in), .b_in(b_in), .sum_out(s_full), .carry_out(c_full));
   seg_approx_adder #(.WIDTH(N), .BLK(W), .GUARD(1), .CARRY_OUT(1'b0)) u_seg_approx_adder_nc (
      .a_in(a_in), .b_in(b_in), .sum_out(s_nc), .carry_out(c_nc));

   // expected result from R1..R4 and R7: slice 0 from zero, predicted carries up to the
   // lowest guard slice, full ripple above it
   function automatic logic [N:0] model(input logic [N-1:0] a, input logic [N-1:0] b, input int k);
      logic [N:0] r = '0;
      logic       cprev = 1'b0;
      for (int i = 0; i < NB; i++) begin
         logic [W:0] t;
         logic       ci;
         if (i == 0) ci = 1'b0;
         else if (i <= NB - k) ci = (({1'b0, a[(i-1)*W +: W]} + {1'b0, b[(i-1)*W +: W]}) >> W) != 0;
         else ci = cprev;
         t = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]} + {{W{1'b0}}, ci};
         r[i*W +: W] = t[W-1:0];
         cprev = t[W];
      end
      r[N] = cprev;
      return r;
   endfunction

   // long chain as defined in R6
   function automatic logic has_chain(input logic [N-1:0] a, input logic [N-1:0] b, input int k);
      logic f = 1'b0;
      for (int i = 1; i <= NB - k; i++) begin
         logic [N:0] lo = ({1'b0, a} & ((({{N{1'b0}}, 1'b1}) << ((i-1)*W)) - 1))
                        + ({1'b0, b} & ((({{N{1'b0}}, 1'b1}) << ((i-1)*W)) - 1));
         logic cin_exact = lo[(i-1)*W];
         if (cin_exact && (&(a[(i-1)*W +: W] ^ b[(i-1)*W +: W]))) f = 1'b1;
      end
      return f;
   endfunction

   task automatic check(input bit ok, input string req, input logic [N:0] act, input logic [N:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
      item_t it;
      @(negedge clk);
      a_in = a;
      b_in = b;
      it.a = a;
      it.b = b;
      it.e_k1 = model(a, b, 1);
      it.e_k2 = model(a, b, 2);
      it.e_full = {1'b0, a} + {1'b0, b};
      it.chain_k1 = has_chain(a, b, 1);
      it.chain_k2 = has_chain(a, b, 2);
      sb.push_back(it);
   endtask

   // monitor
   always @(posedge clk) begin
      if (!rst && sb.size() > 0) begin
         item_t it;
         logic [N:0] exact;
         it = sb.pop_front();
         exact = {1'b0, it.a} + {1'b0, it.b};
         check({c_k1, s_k1} == it.e_k1, "R1 R2 R4 R7 k1", {c_k1, s_k1}, it.e_k1);
         check({c_k2, s_k2} == it.e_k2, "R2 R4 k2", {c_k2, s_k2}, it.e_k2);
         check(s_k1[W-1:0] == exact[W-1:0], "R3", {{(N+1-W){1'b0}}, s_k1[W-1:0]},
               {{(N+1-W){1'b0}}, exact[W-1:0]});
         check({c_full, s_full} == it.e_full, "R5", {c_full, s_full}, it.e_full);
         check((s_k1 == exact[N-1:0]) || it.chain_k1, "R6 k1", {1'b0, s_k1}, exact);
         check((s_k2 == exact[N-1:0]) || it.chain_k2, "R6 k2", {1'b0, s_k2}, exact);
         check(c_nc == 1'b0 && s_nc == it.e_k1[N-1:0], "R7 nocout", {c_nc, s_nc},
               {1'b0, it.e_k1[N-1:0]});
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // zero inputs after reset: all outputs zero (R1, R5)
      drive('0, '0);
      // carry through every slice: dropped past one slice (R2, R6)
      drive(16'hFFFF, 16'h0001);
      drive(16'h0FFF, 16'h0001);
      drive(16'h00FF, 16'h0001);
      // carry into guard slices (R4)
      drive(16'hFF0F, 16'h0001);
      drive(16'hF0F0, 16'h1010);
      // carry out of the top slice (R7)
      drive(16'hFFFF, 16'hFFFF);
      drive(16'h8000, 16'h8000);
      // slice-local carries only
      drive(16'h1234, 16'h4321);
      drive(16'h0808, 16'h0808);
      // long propagate runs fed by a generate
      for (int n = 0; n < 200; n++) begin
         logic [N-1:0] a = N'($urandom);
         drive(a, ~a ^ N'(1 << ($urandom % N)));
      end
      for (int n = 0; n < 600; n++) begin
         drive(N'($urandom), N'($urandom));
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule